// File: doc/BRIEF.md
# Grouped-Interrupt General-Purpose Port

This block is a 32-pin general-purpose port with a small register interface. Software chooses each pin's direction, drives the output pins through a value register or through dedicated set and clear addresses, and can invert the sense of any input pin. Every pin passes through a two-flop synchronizer. A rising edge of a pin's effective level (the synchronized input XOR its inversion bit) records a cause bit.

Pins are grouped in fours of eight. Each group drives one summary interrupt line, which is raised by a rising edge on any pin in that group whose mask bit is set. A mode bit selects how the summary is lowered. In latched mode, the summary falls when software has cleared all eight cause bits of the group. In level mode, the summary falls when all eight effective inputs of the group are low, and cause writes have no effect on it.

The register port is a plain single-cycle write strobe with a combinational read. Reset is asynchronous, active low, and its release is synchronized inside the block.

Top module: `gpio_grp_irq`

## Requirements
- R1: After reset every register reads zero, pin_out, pin_oe and grp_irq are zero, latched mode is selected, and the control address (8) reads 0x11FF0000.
- R2: pin_oe equals the direction register (address 0, 1 = output). A write to the value address (2) updates only those pin_out bits whose direction bit is 1.
- R3: A write to the set address (3) ORs the written bits into pin_out, and a write to the clear address (4) clears the written bits. Both are limited to output pins. Reads of addresses 3 and 4 return zero.
- R4: The inversion register (address 1) is XORed with the synchronized input before edge detection. A read of address 2 returns pin_out for output pins and the effective input for input pins.
- R5: A rising edge of a pin's effective level sets its cause bit (address 5). A pin change made before clock edge k shows in the cause register after edge k+2.
- R6: A rising effective edge on pin p whose mask bit is 1 raises grp_irq[p/8]. A rise on an unmasked pin leaves grp_irq unchanged.
- R7: A write to the cause address clears each cause bit written as 0 and keeps each bit written as 1. In latched mode a group's summary falls on the edge at which such a write leaves all eight of its cause bits zero, and in no other way.
- R8: With bit 10 of the control register set (level mode), a group's summary falls once all eight of its effective inputs are low. Cause writes do not change the summaries in this mode.
- R9: Addresses 6 and 7 both write and read one shared 32-bit mask register.
- R10: The control address reads 0x11FF0000 with the mode flag at bit 10. Addresses 9 to 15 read zero.
- R11: When a masked rising edge occurs on the same edge as a cause write, the new cause bit is set and the summary is raised, even if the write would otherwise have cleared it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 4 | Register address for read and write |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| pin_in | input | 32 | Asynchronous pin inputs |
| pin_out | output | 32 | Driven output levels |
| pin_oe | output | 32 | Output enables (direction) |
| grp_irq | output | 4 | Per-group summary interrupts |

## Verification
Several properties are checked on every cycle. A masked rise always raises its group on the next edge. In latched mode a summary holds unless a cause write or a rise occurs. In level mode a group with all inputs low drops its summary. Output bits of input pins never change, and a rise always leaves its cause bit set.

Other behaviour can only be shown by the bench scenarios. These include the exact two-edge synchronizer latency, the clear-only write semantics of the cause register, a rise and a clearing write colliding on one edge, and level mode ignoring cause writes. The random phase compares every output and read address against a cycle model, while mode, mask and direction change freely.

// File: rtl/gpio_grp_pkg.sv
package gpio_grp_pkg;
  localparam int unsigned REG_AW = 4;
  localparam int unsigned MODE_BIT = 10;
  localparam logic [31:0] CTRL_ID = 32'h11FF_0000;

  typedef enum logic [REG_AW-1:0] {
    ADR_DIR   = 4'd0,
    ADR_INV   = 4'd1,
    ADR_VAL   = 4'd2,
    ADR_SET   = 4'd3,
    ADR_CLR   = 4'd4,
    ADR_CAUSE = 4'd5,
    ADR_MASKA = 4'd6,
    ADR_MASKB = 4'd7,
    ADR_CTRL  = 4'd8
  } gpio_adr_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] stage_d;
    if (s == 0) begin : g_first
      assign stage_d = d;
    end else begin : g_rest
      assign stage_d = stage_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_d;
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_grp_pkg::*;
#(
  parameter int unsigned NPINS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] addr,
  input  logic              wr,
  input  logic [NPINS-1:0]  wdata,
  input  logic [NPINS-1:0]  eff,
  input  logic [NPINS-1:0]  rise,
  output logic [NPINS-1:0]  rdata,
  output logic [NPINS-1:0]  dir_o,
  output logic [NPINS-1:0]  inv_o,
  output logic [NPINS-1:0]  out_o,
  output logic [NPINS-1:0]  mask_o,
  output logic              lvl_o,
  output logic              cause_wr_o,
  output logic [NPINS-1:0]  cause_nxt_o
);
  logic [NPINS-1:0] dir_q, inv_q, out_q, cause_q, mask_q;
  logic             lvl_q;
  logic [NPINS-1:0] out_d, cause_d;
  logic             dir_en, inv_en, out_en, mask_en, lvl_en;

  // Write decode
  always_comb begin
    dir_en  = wr && (addr == ADR_DIR);
    inv_en  = wr && (addr == ADR_INV);
    mask_en = wr && (addr == ADR_MASKA || addr == ADR_MASKB);
    lvl_en  = wr && (addr == ADR_CTRL);
    out_en  = wr && (addr == ADR_VAL || addr == ADR_SET || addr == ADR_CLR);
    cause_wr_o = wr && (addr == ADR_CAUSE);
  end

  // Next-state for output latch and cause
  always_comb begin
    out_d = out_q;
    unique case (addr)
      ADR_VAL: out_d = (out_q & ~dir_q) | (wdata & dir_q);
      ADR_SET: out_d = out_q | (wdata & dir_q);
      ADR_CLR: out_d = out_q & ~(wdata & dir_q);
      default: out_d = out_q;
    endcase
    cause_d = cause_wr_o ? ((cause_q & wdata) | rise) : (cause_q | rise);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= '0;
      inv_q   <= '0;
      out_q   <= '0;
      cause_q <= '0;
      mask_q  <= '0;
      lvl_q   <= 1'b0;
    end else begin
      if (dir_en)  dir_q  <= wdata;
      if (inv_en)  inv_q  <= wdata;
      if (out_en)  out_q  <= out_d;
      if (mask_en) mask_q <= wdata;
      if (lvl_en)  lvl_q  <= wdata[MODE_BIT];
      cause_q <= cause_d;
    end
  end

  // Read mux
  always_comb begin
    rdata = '0;
    unique case (addr)
      ADR_DIR:   rdata = dir_q;
      ADR_INV:   rdata = inv_q;
      ADR_VAL:   rdata = (out_q & dir_q) | (eff & ~dir_q);
      ADR_CAUSE: rdata = cause_q;
      ADR_MASKA,
      ADR_MASKB: rdata = mask_q;
      ADR_CTRL: begin
        rdata = CTRL_ID;
        rdata[MODE_BIT] = lvl_q;
      end
      default:   rdata = '0;
    endcase
  end

  assign dir_o       = dir_q;
  assign inv_o       = inv_q;
  assign out_o       = out_q;
  assign mask_o      = mask_q;
  assign lvl_o       = lvl_q;
  assign cause_nxt_o = cause_d;

  // R2: bits of input pins never change on the output latch
  p_inputs_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((out_q ^ $past(out_q)) & ~$past(dir_q)) == '0);

  // R5: a rise always leaves its cause bit set on the next edge
  p_cause_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise) |=> ((cause_q & $past(rise)) == $past(rise)));

  // R9: both mask addresses load the same register
  p_mask_alias_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && (addr == ADR_MASKA || addr == ADR_MASKB)) |=> (mask_q == $past(wdata)));
endmodule

// File: rtl/gpio_grp_sum.sv
module gpio_grp_sum #(
  parameter int unsigned GW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          level_mode,
  input  logic [GW-1:0] rise_msk,
  input  logic [GW-1:0] eff,
  input  logic          cause_wr,
  input  logic [GW-1:0] cause_nxt,
  output logic          irq
);
  logic irq_q, irq_d;

  always_comb begin
    irq_d = irq_q;
    if (|rise_msk)                                 irq_d = 1'b1;
    else if (level_mode && !(|eff))                irq_d = 1'b0;
    else if (!level_mode && cause_wr && !(|cause_nxt)) irq_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq = irq_q;

  // R6: a masked rise raises the summary
  p_rise_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise_msk) |=> irq);

  // R7: in latched mode the summary holds without a cause write or a rise
  p_latched_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!level_mode && !cause_wr && !(|rise_msk)) |=> (irq == $past(irq)));

  // R8: in level mode all-low inputs drop the summary
  p_level_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (level_mode && !(|eff)) |=> !irq);
endmodule

// File: rtl/gpio_grp_irq.sv
module gpio_grp_irq
  import gpio_grp_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 32,
  parameter int unsigned GRP_SIZE    = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [REG_AW-1:0]   reg_addr,
  input  logic                reg_wr,
  input  logic [NUM_PINS-1:0] reg_wdata,
  output logic [NUM_PINS-1:0] reg_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic [NUM_PINS/GRP_SIZE-1:0] grp_irq
);
  localparam int unsigned NGRP = NUM_PINS / GRP_SIZE;

  // Reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  logic rst_ni;
  assign rst_ni = rst_pipe_q[1];

  logic [NUM_PINS-1:0] pin_sync, eff, eff_q, rise, inv, mask, cause_nxt;
  logic                lvl, cause_wr;

  gpio_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_ni), .d(pin_in), .q(pin_sync)
  );

  assign eff  = pin_sync ^ inv;
  assign rise = eff & ~eff_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) eff_q <= '0;
    else         eff_q <= eff;
  end

  gpio_regs #(.NPINS(NUM_PINS)) u_regs (
    .clk(clk), .rst_n(rst_ni), .addr(reg_addr), .wr(reg_wr), .wdata(reg_wdata),
    .eff(eff), .rise(rise), .rdata(reg_rdata), .dir_o(pin_oe), .inv_o(inv),
    .out_o(pin_out), .mask_o(mask), .lvl_o(lvl), .cause_wr_o(cause_wr),
    .cause_nxt_o(cause_nxt)
  );

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    gpio_grp_sum #(.GW(GRP_SIZE)) u_sum (
      .clk(clk), .rst_n(rst_ni), .level_mode(lvl),
      .rise_msk(rise[g*GRP_SIZE +: GRP_SIZE] & mask[g*GRP_SIZE +: GRP_SIZE]),
      .eff(eff[g*GRP_SIZE +: GRP_SIZE]), .cause_wr(cause_wr),
      .cause_nxt(cause_nxt[g*GRP_SIZE +: GRP_SIZE]), .irq(grp_irq[g])
    );
  end

  // R10: the control address always carries the fixed identity bits
  p_ctrl_rd_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    (reg_addr == ADR_CTRL) |-> (reg_rdata[31:16] == 16'h11FF));
endmodule

// File: tb/gpio_grp_irq_test.sv
`timescale 1ns/1ps
module gpio_grp_irq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out, pin_oe;
  logic [3:0]  grp_irq;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  gpio_grp_irq uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .grp_irq(grp_irq)
  );

  // Cycle model built from the requirements
  logic [31:0] m_dir, m_inv, m_out, m_cause, m_mask, m_s1, m_s2, m_effq;
  logic        m_lvl;
  logic [3:0]  m_grp;

  always @(posedge clk or negedge rst_n) begin : mdl
    logic [31:0] e, r, cn;
    logic        cw;
    if (!rst_n) begin
      m_dir = '0; m_inv = '0; m_out = '0; m_cause = '0; m_mask = '0;
      m_s1 = '0; m_s2 = '0; m_effq = '0; m_lvl = 1'b0; m_grp = '0;
    end else begin
      e  = m_s2 ^ m_inv;
      r  = e & ~m_effq;
      cw = reg_wr && reg_addr == 4'd5;
      cn = cw ? ((m_cause & reg_wdata) | r) : (m_cause | r);
      for (int g = 0; g < 4; g++) begin
        if (|(r[g*8 +: 8] & m_mask[g*8 +: 8]))       m_grp[g] = 1'b1;
        else if (m_lvl && e[g*8 +: 8] == 8'h0)        m_grp[g] = 1'b0;
        else if (!m_lvl && cw && cn[g*8 +: 8] == 8'h0) m_grp[g] = 1'b0;
      end
      if (reg_wr) begin
        case (reg_addr)
          4'd0: m_dir = reg_wdata;
          4'd1: m_inv = reg_wdata;
          4'd2: m_out = (m_out & ~m_dir) | (reg_wdata & m_dir);
          4'd3: m_out = m_out | (reg_wdata & m_dir);
          4'd4: m_out = m_out & ~(reg_wdata & m_dir);
          4'd6, 4'd7: m_mask = reg_wdata;
          4'd8: m_lvl = reg_wdata[10];
          default: ;
        endcase
      end
      m_cause = cn;
      m_effq  = e;
      m_s2    = m_s1;
      m_s1    = pin_in;
    end
  end

  function automatic logic [31:0] rd_model(input logic [3:0] a);
    case (a)
      4'd0: return m_dir;
      4'd1: return m_inv;
      4'd2: return (m_out & m_dir) | ((m_s2 ^ m_inv) & ~m_dir);
      4'd5: return m_cause;
      4'd6, 4'd7: return m_mask;
      4'd8: return 32'h11FF_0000 | (32'(m_lvl) << 10);
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
    reg_addr = a;
    #1;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    idle(3);
    rst_n = 1'b1;
    idle(5);

    // R1 reset state
    for (int a = 0; a < 9; a++)
      rd(4'(a), (a == 8) ? 32'h11FF_0000 : 32'h0, "R1 reset read");
    chk("R1 grp_irq", {28'h0, grp_irq}, 32'h0);
    chk("R1 pin_oe", pin_oe, 32'h0);

    // R2 value write limited to outputs
    wr(4'd0, 32'h0000_FFFF);
    wr(4'd2, 32'hFFFF_FFFF);
    chk("R2 pin_out", pin_out, 32'h0000_FFFF);
    chk("R2 pin_oe", pin_oe, 32'h0000_FFFF);

    // R3 set / clear
    wr(4'd0, 32'h00FF_00FF);
    wr(4'd3, 32'hFFFF_FFFF);
    chk("R3 set", pin_out, 32'h00FF_FFFF);
    wr(4'd4, 32'hFFFF_0000);
    chk("R3 clear", pin_out, 32'h0000_FFFF);
    rd(4'd3, 32'h0, "R3 set reads zero");
    rd(4'd4, 32'h0, "R3 clear reads zero");

    // R4 inversion before edge detection
    wr(4'd0, 32'h0);
    wr(4'd1, 32'h1);
    idle(2);
    rd(4'd2, 32'h1, "R4 value read inverted input");
    rd(4'd5, 32'h1, "R4 cause from inversion");
    wr(4'd1, 32'h0);
    wr(4'd5, 32'h0);
    rd(4'd5, 32'h0, "R7 cause cleared");

    // R5 latency: change before edge k, cause after k+2
    @(negedge clk);
    pin_in = 32'h0000_0100;
    reg_addr = 4'd5;
    @(negedge clk); #1;
    chk("R5 cause after one edge", reg_rdata, 32'h0);
    @(negedge clk); #1;
    chk("R5 cause after two edges", reg_rdata, 32'h0);
    @(negedge clk); #1;
    chk("R5 cause after three edges", reg_rdata, 32'h0000_0100);
    chk("R6 unmasked no irq", {28'h0, grp_irq}, 32'h0);

    // R6 masked rise raises group 2
    wr(4'd6, 32'h0001_0000);
    @(negedge clk);
    pin_in = 32'h0001_0100;
    idle(3);
    chk("R6 grp_irq", {28'h0, grp_irq}, 32'h4);
    rd(4'd5, 32'h0001_0100, "R5 cause two pins");

    // R7 latched clear semantics
    wr(4'd5, 32'hFFFF_FFFF);
    chk("R7 write ones keeps irq", {28'h0, grp_irq}, 32'h4);
    rd(4'd5, 32'h0001_0100, "R7 write ones keeps cause");
    wr(4'd5, 32'hFFFE_FFFF);
    chk("R7 group cleared", {28'h0, grp_irq}, 32'h0);
    rd(4'd5, 32'h0000_0100, "R7 other bit kept");

    // R9 mask alias
    wr(4'd7, 32'h0003_0000);
    rd(4'd6, 32'h0003_0000, "R9 alias read");

    // R11 rise and clearing write on the same edge
    @(negedge clk);
    pin_in = 32'h0003_0100;
    @(negedge clk);
    @(negedge clk);
    reg_addr = 4'd5; reg_wdata = 32'h0; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    chk("R11 irq set wins", {28'h0, grp_irq}, 32'h4);
    rd(4'd5, 32'h0002_0000, "R11 cause set wins");

    // R8 level mode
    wr(4'd8, 32'h0000_0400);
    rd(4'd8, 32'h11FF_0400, "R10 ctrl level flag");
    wr(4'd5, 32'h0);
    chk("R8 cause write ignored", {28'h0, grp_irq}, 32'h4);
    @(negedge clk);
    pin_in = 32'h0002_0100;
    idle(3);
    chk("R8 one input still high", {28'h0, grp_irq}, 32'h4);
    @(negedge clk);
    pin_in = 32'h0000_0100;
    @(negedge clk);
    @(negedge clk);
    chk("R8 before fall seen", {28'h0, grp_irq}, 32'h4);
    @(negedge clk);
    chk("R8 all low drops", {28'h0, grp_irq}, 32'h0);
    wr(4'd8, 32'h0);
    rd(4'd8, 32'h11FF_0000, "R10 ctrl latched");
    rd(4'd12, 32'h0, "R10 unused address");

    // Random phase against the cycle model
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      chk("R2 random pin_out", pin_out, m_out);
      chk("R2 random pin_oe", pin_oe, m_dir);
      chk("R6 random grp_irq", {28'h0, grp_irq}, {28'h0, m_grp});
      chk("R4 random rdata", reg_rdata, rd_model(reg_addr));
      if ($urandom_range(0, 2) == 0) pin_in = pin_in ^ (32'h1 << $urandom_range(0, 31));
      if ($urandom_range(0, 40) == 0) pin_in = 32'h0;
      reg_wr    = ($urandom_range(0, 3) == 0);
      reg_addr  = 4'($urandom_range(0, 9));
      case ($urandom_range(0, 5))
        0: reg_wdata = 32'h0;
        1: reg_wdata = 32'hFFFF_FFFF;
        default: reg_wdata = $urandom;
      endcase
    end
    @(negedge clk);
    reg_wr = 1'b0;

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule